// File: doc/BRIEF.md
# Left-justified stereo serial receiver

This block receives two-channel serial audio as a slave and turns it into parallel 16-bit sample pairs. The bit clock, the frame sync and the serial data come from an external transmitter. All three are brought into a faster system clock domain through two-flop synchronizers and are sampled there. The system clock must run at least four times faster than the bit clock.

The transmitter launches data on the rising edge of the bit clock. The receiver takes one sample at each falling edge of the bit clock. A change in frame-sync level starts a new channel slot, and the bit sampled at that change is already the most significant bit of the slot's sample, because the format is left-justified with no one-bit delay. Frame sync high carries the left channel and frame sync low carries the right channel. When the sixteenth bit of a right slot arrives after a complete left slot, both samples appear on the outputs together with a one-cycle valid pulse.

A slot that ends before sixteen bits have arrived raises a one-cycle error pulse, and the pair it belongs to is dropped. Any bits after the sixteenth in a slot are ignored.

The controller is a four-state machine:
- **ST_IDLE**: waiting for the first bit sample. On the first falling edge of the bit clock it moves to ST_HUNT.
- **ST_HUNT**: waiting for a rising edge of the frame sync. On that edge it moves to ST_LEFT.
- **ST_LEFT**: collecting the left sample. A falling edge of the frame sync moves it to ST_RIGHT.
- **ST_RIGHT**: collecting the right sample. A rising edge of the frame sync moves it to ST_LEFT.

Top module: `lj_stereo_rx`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, and in the cycle after it, `pair_valid` and `slot_short` are 0 and `left_out` and `right_out` are 0.
- R2: Serial data is captured only at falling edges of the bit clock. Each sample is taken most significant bit first. The bit captured at the sample point where the frame sync has changed level is bit 15 of the new sample.
- R3: Frame sync high marks a left slot and low marks a right slot. `pair_valid` pulses for exactly one cycle after the sixteenth bit of a right slot that follows a complete left slot. It carries the left sample on `left_out` and the right sample on `right_out`.
- R4: Bits after the sixteenth bit of a slot have no effect on the presented sample.
- R5: A left or right slot that ends after fewer than 16 bits pulses `slot_short` for one cycle. No pair containing that slot is presented, and `slot_short` and `pair_valid` are never high in the same cycle.
- R6: After reset, the receiver ignores all traffic until it sees a rising edge of the frame sync. A rising edge means a sample with frame sync high that follows a sample with frame sync low. Traffic before that edge produces neither a pair nor an error.
- R7: `left_out` and `right_out` keep their values in every cycle in which `pair_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock from the transmitter (asynchronous) |
| fsync_in | input | 1 | Frame sync: high = left slot, low = right slot (asynchronous) |
| sdata_in | input | 1 | Serial data, launched on bit-clock rising edges (asynchronous) |
| pair_valid | output | 1 | One-cycle strobe: a new stereo pair is on the outputs |
| left_out | output | 16 | Left sample of the last presented pair |
| right_out | output | 16 | Right sample of the last presented pair |
| slot_short | output | 1 | One-cycle strobe: a slot ended with fewer than 16 bits |

## Verification
The checker watches every cycle for the following:
- both strobes are single-cycle and never high together;
- a pair is presented only right after a bit-clock falling-edge sample;
- the sample outputs stay still between pairs;
- the outputs are quiet just after reset.

The following can only be shown by the bench's scenarios, whose reference model queues the pairs it expects from the serial traffic it drives:
- whether the sample bits are assembled in the right order and slot;
- whether bits after the sixteenth are ignored;
- whether short slots discard their pair;
- whether traffic before the first frame-sync rising edge stays silent.

// File: rtl/lj_rx_pkg.sv
package lj_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } rx_state_t;

endpackage

// File: rtl/lj_rx_sync.sv
module lj_rx_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta, stable;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta   <= 1'b0;
                stable <= 1'b0;
            end else begin
                meta   <= d[i];
                stable <= meta;
            end
        end
        assign q[i] = stable;
    end
endmodule

// File: rtl/lj_rx_edge.sv
module lj_rx_edge (
    input  logic clk,
    input  logic rst,
    input  logic bclk_s,
    output logic bit_fall
);
    logic bclk_d;

    always_ff @(posedge clk) begin
        if (rst) bclk_d <= 1'b0;
        else     bclk_d <= bclk_s;
    end

    // A falling edge of the bit clock is the sample point for data launched on its rising edge.
    assign bit_fall = bclk_d & ~bclk_s;
endmodule

// File: rtl/lj_rx_fsm.sv
module lj_rx_fsm
    import lj_rx_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_fall,
    input  logic                smp_fs,
    input  logic                smp_sd,
    output logic                pair_valid,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                slot_short
);
    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

    rx_state_t state, state_nx;
    logic                fs_last;
    logic [CNT_W-1:0]    bit_cnt;
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] left_hold;
    logic                left_ok;
    logic                slot_edge;
    logic                in_slot;
    logic [SAMPLE_W-1:0] shifted;

    assign slot_edge = bit_fall && (smp_fs != fs_last);
    assign in_slot   = (state == ST_LEFT) || (state == ST_RIGHT);
    assign shifted   = {shreg[SAMPLE_W-2:0], smp_sd};

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (bit_fall) state_nx = ST_HUNT;
            ST_HUNT:  if (slot_edge && smp_fs) state_nx = ST_LEFT;
            ST_LEFT:  if (slot_edge) state_nx = ST_RIGHT;
            ST_RIGHT: if (slot_edge) state_nx = ST_LEFT;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_last    <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            left_hold  <= '0;
            left_ok    <= 1'b0;
            pair_valid <= 1'b0;
            slot_short <= 1'b0;
            left_out   <= '0;
            right_out  <= '0;
        end else begin
            pair_valid <= 1'b0;
            slot_short <= 1'b0;
            if (bit_fall) fs_last <= smp_fs;
            if (slot_edge && (state_nx == ST_LEFT || state_nx == ST_RIGHT)) begin
                // Left-justified: the bit at the frame-sync change is the MSB.
                shreg   <= {{(SAMPLE_W-1){1'b0}}, smp_sd};
                bit_cnt <= CNT_W'(1);
                if (in_slot && bit_cnt < FULL) slot_short <= 1'b1;
                if (state_nx == ST_LEFT) left_ok <= 1'b0;
            end else if (bit_fall && in_slot && bit_cnt < FULL) begin
                shreg   <= shifted;
                bit_cnt <= bit_cnt + CNT_W'(1);
                if (bit_cnt == LAST) begin
                    if (state == ST_LEFT) begin
                        left_hold <= shifted;
                        left_ok   <= 1'b1;
                    end else if (left_ok) begin
                        left_out   <= left_hold;
                        right_out  <= shifted;
                        pair_valid <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lj_stereo_rx.sv
module lj_stereo_rx #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_in,
    input  logic                fsync_in,
    input  logic                sdata_in,
    output logic                pair_valid,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                slot_short
);
    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] synced;
    logic              bit_fall;

    assign raw_in = {bclk_in, fsync_in, sdata_in};

    lj_rx_sync #(.N(N_SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (synced)
    );

    lj_rx_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .bclk_s   (synced[2]),
        .bit_fall (bit_fall)
    );

    lj_rx_fsm #(.SAMPLE_W(SAMPLE_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bit_fall   (bit_fall),
        .smp_fs     (synced[1]),
        .smp_sd     (synced[0]),
        .pair_valid (pair_valid),
        .left_out   (left_out),
        .right_out  (right_out),
        .slot_short (slot_short)
    );
endmodule

// File: rtl/lj_rx_checker.sv
module lj_rx_checker #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                bit_fall,
    input logic                pair_valid,
    input logic                slot_short,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!pair_valid && !slot_short && left_out == '0 && right_out == '0)); // R1

    AST_PAIR_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> $past(bit_fall)); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid); // R3

    AST_SHORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        slot_short |=> !slot_short); // R5

    AST_NO_BOTH_STROBES: assert property (@(posedge clk) disable iff (rst)
        !(pair_valid && slot_short)); // R5

    AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> ($stable(left_out) && $stable(right_out))); // R7
endmodule

bind lj_stereo_rx lj_rx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_fall   (bit_fall),
    .pair_valid (pair_valid),
    .slot_short (slot_short),
    .left_out   (left_out),
    .right_out  (right_out)
);

// File: tb/test_lj_stereo_rx.sv
module test_lj_stereo_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
    logic        pair_valid, slot_short;
    logic [15:0] left_out, right_out;

    int checks = 0, errors = 0;
    int valid_seen = 0, short_seen = 0, short_exp = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    logic [31:0] last_pair = 32'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lj_stereo_rx i_lj_stereo_rx (
        .clk        (clk),
        .rst        (rst),
        .bclk_in    (bclk),
        .fsync_in   (fsync),
        .sdata_in   (sdata),
        .pair_valid (pair_valid),
        .left_out   (left_out),
        .right_out  (right_out),
        .slot_short (slot_short)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model, evaluated every clock: each strobe must match the queue of expected pairs.
    always @(negedge clk) begin
        if (!rst) begin
            if (slot_short) short_seen++;
            if (pair_valid) begin
                valid_seen++;
                if (exp_q.size() == 0) begin
                    check(0, "R3 unexpected pair", {left_out, right_out}, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check({left_out, right_out} === e, "R2/R3/R4 pair", {left_out, right_out}, e);
                    last_pair = e;
                end
            end
        end
    end

    // Launch on the rising bit-clock edge, hold through the falling edge.
    task automatic send_slot(input logic fs, input logic [31:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bclk = 1'b1; fsync = fs; sdata = bits[31-i];
            repeat (HALF_BIT) @(negedge clk);
            bclk = 1'b0;
            repeat (HALF_BIT - 1) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [31:0] l, input int nl, input logic [31:0] r, input int nr);
        if (nl >= 16 && nr >= 16) exp_q.push_back({l[31:16], r[31:16]});
        if (nl < 16) short_exp++;
        if (nr < 16) short_exp++;
        send_slot(1'b1, l, nl);
        send_slot(1'b0, r, nr);
    endtask

    task automatic print_summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            print_summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs quiet during reset
        check(!pair_valid && !slot_short, "R1 strobes in reset", {30'b0, pair_valid, slot_short}, 32'h0);
        check(left_out == 0 && right_out == 0, "R1 data in reset", {left_out, right_out}, 32'h0);
        rst = 1'b0;
        // R6: a left-looking slot before any rising frame-sync edge, then a short low slot: all ignored
        send_slot(1'b1, 32'hDEAD_BEEF, 16);
        send_slot(1'b0, 32'h1234_0000, 5);
        repeat (4) @(negedge clk);
        check(valid_seen == 0 && short_seen == 0, "R6 silent before first edge", valid_seen + short_seen, 32'h0);
        // R2/R3: several bit patterns
        send_frame(32'hA5C3_0000, 16, 32'h1234_0000, 16);
        send_frame(32'hFFFF_0000, 16, 32'h0000_0000, 16);
        send_frame(32'h8001_0000, 16, 32'h7FFE_0000, 16);
        // R4: 20-bit slots with nonzero tails
        send_frame(32'h3C5A_F000, 20, 32'h9669_B000, 20);
        // R5: short left (pair dropped), then short right flagged at the next left
        send_frame(32'h1111_0000, 10, 32'h2222_0000, 16);
        send_frame(32'h3333_0000, 16, 32'h4444_0000, 12);
        send_frame(32'h0F0F_0000, 16, 32'hF0F0_0000, 16);
        repeat (20) @(negedge clk);
        // R7: outputs hold the last pair after the strobe
        check({left_out, right_out} === last_pair, "R7 hold", {left_out, right_out}, last_pair);
        check(exp_q.size() == 0, "R3 all pairs presented", exp_q.size(), 32'h0);
        check(valid_seen == 5, "R5 dropped pairs", valid_seen, 32'd5);
        check(short_seen == short_exp, "R5 short slot count", short_seen, short_exp);
        done = 1;
        print_summary();
        $finish;
    end
endmodule